// File: doc/BRIEF.md
# Programmable-Increment Time-of-Day Counter

This block keeps a free-running 64-bit time value for hardware timestamping. A prescaler counts input clock cycles. Each time it reaches a programmable period it adds a programmable 24-bit step to the 64-bit count, and on all other cycles the count holds. Software scales the step upward by a shift. The low-order bits of the count then hold fractions of a nanosecond, and small rate corrections can be made by changing the step. The count wraps silently at 2^64. Because of the scaling this can happen within hours, so software must sample it often enough to notice.

Software uses a simple strobe register port with 32-bit data and a 2-bit address. The port reaches a setup word, the lower half of the count and the upper half of the count. Reading the lower half freezes the upper half into a shadow register, so a low-then-high read pair forms one coherent 64-bit sample. Writing the lower half only stages the value. Writing the upper half then loads all 64 bits at once. The port carries register accesses, not a data stream, so it has no valid/ready handshake: every strobe completes in the cycle it is presented, and no back-pressure exists.

Top module: `tod_counter`

## Requirements
- R1: A synchronous active-high `rst` clears the count, the prescaler, the setup word, the staging register and the shadow register, so reads of every address return 0 after reset.
- R2: The setup word is at address 0. Bits 31:24 hold the period P and bits 23:0 hold the step S, and a read of address 0 returns the last value written.
- R3: With P nonzero the count increases by S (zero-extended to 64 bits) on exactly one clock edge out of every P, and holds on the other edges.
- R4: With P equal to 0 the count never advances.
- R5: A write to the setup word restarts the prescaler. With the new period P, the first advance happens on the P-th clock edge after the write edge, and no advance happens on the write edge itself.
- R6: A read of address 1 copies the upper 32 bits of the count, as they were in that cycle, into a shadow register. A read of address 2 returns the shadow, not the live upper half.
- R7: A write to address 1 stages 32 bits and leaves the count unchanged. A write to address 2 loads {write data, staged value} into the full 64-bit count on that edge.
- R8: A load and an advance on the same edge leave exactly the loaded value; the step is not added.
- R9: Past 2^64 - 1 the count wraps modulo 2^64, with no saturation and no flag.
- R10: Address 1 returns the live lower 32 bits of the count in the cycle of the read. Address 3 reads as 0, and writes to it have no effect.
- R11: `reg_rdata` is combinational from the current state and the strobe. It is 0 in any cycle where `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_addr | input | 2 | Register select: 0 setup, 1 count low, 2 count high, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |

## Verification
The properties assume that `reg_rd` and `reg_wr` are never high together, and that each strobe lasts a single cycle. Under that assumption a load, a staging write and a shadow capture can be attributed to exactly one access. The stimulus issues at most one access per cycle and drives it on the falling edge. Addresses stay in 0 to 3, and the bench also uses the unused address to probe R10.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SETUP = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_HIGH  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tod_prescaler.sv
`timescale 1ns/1ps
module tod_prescaler #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic             running;

  assign running = (period != '0);
  assign tick    = running && !restart && (cnt_q == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart || !running || tick) cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned INC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [INC_W-1:0] incr,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned PAD_W = CNT_W - INC_W;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] incr_ext;

  assign incr_ext = {{PAD_W{1'b0}}, incr};
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (load) count_q <= load_val;
    else if (step) count_q <= count_q + incr_ext;
  end
endmodule

// File: rtl/tod_regif.sv
`timescale 1ns/1ps
module tod_regif
  import tod_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned CNT_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [REG_W-1:0]  setup,
  output logic              setup_wr,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [REG_W-1:0]  shadow,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] setup_q;
  logic [REG_W-1:0] stage_q;
  logic [REG_W-1:0] shadow_q;
  logic             hit_setup, hit_low, hit_high;

  assign hit_setup = (addr == SEL_SETUP);
  assign hit_low   = (addr == SEL_LOW);
  assign hit_high  = (addr == SEL_HIGH);

  assign setup_wr = wr && hit_setup;
  assign load     = wr && hit_high;
  assign load_val = {wdata, stage_q};
  assign setup    = setup_q;
  assign shadow   = shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q  <= '0;
      stage_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (setup_wr)       setup_q  <= wdata;
      if (wr && hit_low)  stage_q  <= wdata;
      if (rd && hit_low)  shadow_q <= count[CNT_W-1:REG_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        SEL_SETUP: rdata = setup_q;
        SEL_LOW:   rdata = count[REG_W-1:0];
        SEL_HIGH:  rdata = shadow_q;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned PER_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int unsigned CNT_W = 2 * REG_W;
  localparam int unsigned INC_W = REG_W - PER_W;

  logic [REG_W-1:0] setup;
  logic             setup_wr;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [REG_W-1:0] shadow_hi;
  logic [CNT_W-1:0] count;
  logic [PER_W-1:0] period;
  logic [INC_W-1:0] incr;
  logic             tick;

  assign period = setup[REG_W-1 -: PER_W];
  assign incr   = setup[INC_W-1:0];

  tod_regif #(.REG_W(REG_W), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst(rst), .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .count(count), .setup(setup), .setup_wr(setup_wr),
    .load(load), .load_val(load_val), .shadow(shadow_hi), .rdata(reg_rdata)
  );

  tod_prescaler #(.PER_W(PER_W)) u_presc (
    .clk(clk), .rst(rst), .restart(setup_wr), .period(period), .tick(tick)
  );

  tod_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_accum (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .step(tick), .incr(incr), .count(count)
  );
endmodule

// File: rtl/tod_counter_chk.sv
`timescale 1ns/1ps
module tod_counter_chk
  import tod_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned PER_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      reg_rd,
  input logic                      reg_wr,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [REG_W-1:0]          reg_wdata,
  input logic                      tick,
  input logic                      setup_wr,
  input logic                      load,
  input logic [PER_W-1:0]          period,
  input logic [REG_W-PER_W-1:0]    incr,
  input logic [2*REG_W-1:0]        count,
  input logic [REG_W-1:0]          shadow_hi,
  input logic [REG_W-1:0]          reg_rdata
);
  localparam int unsigned CNT_W = 2 * REG_W;
  localparam int unsigned PAD_W = CNT_W - (REG_W - PER_W);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (count == '0 && shadow_hi == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> count == $past(count) + {{PAD_W{1'b0}}, $past(incr)});

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(count));

  p_halt_r4: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |-> !tick);

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    setup_wr |-> !tick);

  p_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == SEL_LOW) |=> shadow_hi == $past(count[CNT_W-1:REG_W]));

  p_stage_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == SEL_LOW && !tick) |=> $stable(count));

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> count[CNT_W-1:REG_W] == $past(reg_wdata));

  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |-> reg_rdata == '0);
endmodule

bind tod_counter tod_counter_chk #(.REG_W(REG_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tick(tick), .setup_wr(setup_wr), .load(load),
  .period(period), .incr(incr), .count(count), .shadow_hi(shadow_hi),
  .reg_rdata(reg_rdata)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [63:0] m_count = 64'd0;
  logic [31:0] m_setup = 32'd0;
  logic [31:0] m_stage = 32'd0;
  logic [31:0] m_shadow = 32'd0;
  int          m_pre = 0;

  tod_counter dut (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    int per;
    bit adv;
    logic [63:0] old;
    cycles++;
    if (rst) begin
      m_count = 0; m_setup = 0; m_stage = 0; m_shadow = 0; m_pre = 0;
    end else begin
      old = m_count;
      per = int'(m_setup[31:24]);
      adv = 1'b0;
      if (reg_wr && reg_addr == 2'd0) m_pre = 0;
      else if (per == 0) m_pre = 0;
      else if (m_pre == per - 1) begin adv = 1'b1; m_pre = 0; end
      else m_pre = m_pre + 1;
      if (reg_wr && reg_addr == 2'd2) m_count = {reg_wdata, m_stage};
      else if (adv) m_count = old + {40'd0, m_setup[23:0]};
      if (reg_rd && reg_addr == 2'd1) m_shadow = old[63:32];
      if (reg_wr && reg_addr == 2'd1) m_stage = reg_wdata;
      if (reg_wr && reg_addr == 2'd0) m_setup = reg_wdata;
    end
  end

  function automatic logic [31:0] expect_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_setup;
      2'd1:    return m_count[31:0];
      2'd2:    return m_shadow;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic op(input bit rd, input bit wr, input logic [1:0] a,
                    input logic [31:0] d, input string tag);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    if (rd) check(tag, reg_rdata, expect_rd(a));
    else    check("R11", reg_rdata, 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 2'd0, 32'd0, "R11");
  endtask

  task automatic watch_low(input int n, input string tag);
    for (int i = 0; i < n; i++) op(1'b1, 1'b0, 2'd1, 32'd0, tag);
  endtask

  task automatic put(input logic [1:0] a, input logic [31:0] d, input string tag);
    op(1'b0, 1'b1, a, d, tag);
  endtask

  initial begin
    while (!done && cycles < 100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected < %0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: everything reads zero after reset
    op(1'b1, 1'b0, 2'd0, 0, "R1");
    op(1'b1, 1'b0, 2'd1, 0, "R1");
    op(1'b1, 1'b0, 2'd2, 0, "R1");
    // R4: default setup leaves the count frozen
    watch_low(5, "R4");
    // R2, R3: period 1, step 40<<18
    put(2'd0, {8'd1, 24'(40 << 18)}, "R2");
    op(1'b1, 1'b0, 2'd0, 0, "R2");
    watch_low(6, "R3");
    // R5, R3: period 3, step 125<<14
    put(2'd0, {8'd3, 24'(125 << 14)}, "R5");
    watch_low(10, "R5");
    // R3: period 1, step 26<<19; then an odd period with a large step
    put(2'd0, {8'd1, 24'(26 << 19)}, "R3");
    watch_low(4, "R3");
    put(2'd0, {8'd7, 24'hFFFFFF}, "R3");
    watch_low(16, "R3");
    // R5: rewrite mid-count restarts the prescaler
    put(2'd0, {8'd7, 24'hFFFFFF}, "R5");
    watch_low(9, "R5");
    // R4: period zero halts
    put(2'd0, {8'd0, 24'h123456}, "R4");
    watch_low(6, "R4");
    // R7: staging write leaves the count alone, high write loads
    put(2'd1, 32'hFFFF_FFF0, "R7");
    watch_low(2, "R7");
    put(2'd2, 32'h0000_0001, "R7");
    watch_low(1, "R7");
    // R6: low read freezes high half while the count carries across
    put(2'd0, {8'd1, 24'd8}, "R6");
    watch_low(1, "R6");
    idle(4);
    op(1'b1, 1'b0, 2'd2, 0, "R6");
    watch_low(1, "R6");
    op(1'b1, 1'b0, 2'd2, 0, "R6");
    // R8: load lands on an advance edge
    put(2'd1, 32'hAAAA_0000, "R8");
    put(2'd2, 32'h5555_5555, "R8");
    watch_low(1, "R8");
    op(1'b1, 1'b0, 2'd2, 0, "R8");
    // R9: wrap past all ones
    put(2'd0, {8'd1, 24'h10}, "R9");
    put(2'd1, 32'hFFFF_FFF8, "R9");
    put(2'd2, 32'hFFFF_FFFF, "R9");
    watch_low(3, "R9");
    op(1'b1, 1'b0, 2'd2, 0, "R9");
    // R10: unused address reads zero, writes ignored
    op(1'b1, 1'b0, 2'd3, 0, "R10");
    put(2'd3, 32'hDEAD_BEEF, "R10");
    op(1'b1, 1'b0, 2'd0, 0, "R10");
    watch_low(1, "R10");
    op(1'b1, 1'b0, 2'd2, 0, "R10");
    // R1: reset mid-run
    @(negedge clk); reg_rd = 0; reg_wr = 0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    op(1'b1, 1'b0, 2'd0, 0, "R1");
    op(1'b1, 1'b0, 2'd1, 0, "R1");
    op(1'b1, 1'b0, 2'd2, 0, "R1");
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule